// File: doc/BRIEF.md
# Reset Cause Register

This block gathers every reset request in the chip, turns the qualified ones into a single stretched system reset, and keeps one 8-bit register that tells software which event caused the most recent reset. Most bits have two roles. A write stores an enable (for the supply monitor, missing-clock detector, comparator and real-time clock) or a software force. A read always returns the cause flags. Read-modify-write bus operations take the stored enables as their read operand, never the flags.

Power-on is the asynchronous active-low input `por_n`. It clears all enables, sets only the supply flag, and holds the reset output asserted. Every other source is a synchronous pulse. The watchdog, external pin and flash-error requests always cause a reset. The gated sources cause a reset only while their enable is set. The comparator request is active-low. If several qualified requests fall in one cycle, a fixed priority picks the single flag that is recorded. The bus is a plain single-cycle register port, so no valid/ready handshake applies.

Top module: `rstcause_ctrl`

## Requirements
- R1: While `por_n` is low, `sys_rst` is 1, a read returns 0x02 (bit 1 alone), and all four enable outputs are 0. After `por_n` rises, `sys_rst` stays 1 for exactly 16 rising clock edges.
- R2: A read at address `REG_ADDR` (default 0x3C) returns the flag register, and a read at any other address returns 0. A write to any other address changes nothing.
- R3: With `bus_op`=0, a write stores `bus_wdata` bits 7, 5, 2 and 1 as the enables for RTC, comparator, missing-clock and supply monitor. These drive `en_rtc`, `en_cmp`, `en_mcd` and `en_vmon`. A read still returns the flags.
- R4: `mcd_req`, low `cmp_n`, `rtc_req` and `vmon_req` cause a reset only while the matching enable is 1. Otherwise they leave `sys_rst` at 0 and the flags unchanged.
- R5: `pin_req`, `wdt_req` and `flash_req` always cause a reset, setting flag bit 0, 3 and 6 respectively.
- R6: A write whose resulting value has bit 4 set forces a reset that sets flag bit 4. A write with bit 4 clear forces nothing.
- R7: After any reset other than power-on, exactly one flag reads 1. The enables keep the values they had before that reset. A supply-monitor reset sets bit 1, MCD sets bit 2, comparator bit 5, RTC bit 7.
- R8: A qualified request sampled at edge k raises `sys_rst` after edge k and drops it after edge k+16.
- R9: While `sys_rst` is 1, requests and bus writes are ignored: the flags, the enables and the end of the stretch do not change.
- R10: Requests in the same cycle are resolved with the priority supply monitor (bit 1) > pin (0) > watchdog (3) > missing-clock (2) > flash (6) > comparator (5) > RTC (7) > software (4).
- R11: `bus_op`=1 writes enables OR `bus_wdata`, and `bus_op`=2 writes enables AND NOT `bus_wdata`. The bit-4 force uses that result, so a set operation with bit 4 forces a reset and a clear operation does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| pin_req | input | 1 | External pin reset request |
| wdt_req | input | 1 | Watchdog timeout |
| mcd_req | input | 1 | Missing-clock timeout |
| flash_req | input | 1 | Flash access error |
| cmp_n | input | 1 | Comparator reset request, active low |
| rtc_req | input | 1 | RTC alarm or oscillator failure |
| vmon_req | input | 1 | Supply monitor trip |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_op | input | 2 | 0 write, 1 set bits, 2 clear bits, 3 write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (flags) |
| sys_rst | output | 1 | Combined system reset |
| en_rtc | output | 1 | RTC reset enable |
| en_cmp | output | 1 | Comparator reset enable |
| en_mcd | output | 1 | Missing-clock reset enable |
| en_vmon | output | 1 | Supply monitor reset enable |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is hardware requests from several sources together with a software force write. The second pair is an enable write together with the gated request whose enable it changes. The bench sweeps all 16 enable combinations against all 256 subsets of the eight sources, with the force issued as a bus write in the same cycle. From the enable mask and the priority order it computes the single expected flag, or no reset at all. A second collision is a request or force write that arrives during an active stretch; the bench judges it by an unchanged flag, unchanged enables and an unmoved end of reset.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;
  localparam int NBITS = 8;

  // Flag / enable bit positions (software decodes these)
  localparam int B_PIN   = 0;
  localparam int B_VMON  = 1;
  localparam int B_MCD   = 2;
  localparam int B_WDT   = 3;
  localparam int B_SW    = 4;
  localparam int B_CMP   = 5;
  localparam int B_FLASH = 6;
  localparam int B_RTC   = 7;

  localparam logic [NBITS-1:0] EN_MASK  = 8'hA6;  // storable enables
  localparam logic [NBITS-1:0] POR_FLAG = 8'h02;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_ALT   = 2'd3
  } bus_op_e;

  // rank 0 = highest priority; returns the flag bit position
  function automatic logic [2:0] prio_bit(input int rank);
    case (rank)
      0: prio_bit = 3'(B_VMON);
      1: prio_bit = 3'(B_PIN);
      2: prio_bit = 3'(B_WDT);
      3: prio_bit = 3'(B_MCD);
      4: prio_bit = 3'(B_FLASH);
      5: prio_bit = 3'(B_CMP);
      6: prio_bit = 3'(B_RTC);
      default: prio_bit = 3'(B_SW);
    endcase
  endfunction
endpackage

// File: rtl/rstcause_arbiter.sv
module rstcause_arbiter
  import rstcause_pkg::*;
(
  input  logic [NBITS-1:0] req,
  output logic [NBITS-1:0] grant,
  output logic             any
);
  always_comb begin
    grant = '0;
    // walk from lowest to highest rank so the highest wins last
    for (int r = NBITS - 1; r >= 0; r--) begin
      if (req[prio_bit(r)]) begin
        grant = '0;
        grant[prio_bit(r)] = 1'b1;
      end
    end
    any = |req;
  end
endmodule

// File: rtl/rstcause_stretch.sv
module rstcause_stretch #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic trig,
  output logic active
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            cnt_q <= CW'(LEN);
    else if (trig)         cnt_q <= CW'(LEN);
    else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign active = !por_n || (cnt_q != '0);
endmodule

// File: rtl/rstcause_regs.sv
module rstcause_regs
  import rstcause_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h3C
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [1:0]        bus_op,
  input  logic [NBITS-1:0]  bus_wdata,
  input  logic              in_rst,
  input  logic              capture,
  input  logic [NBITS-1:0]  cause,
  output logic [NBITS-1:0]  rdata,
  output logic [NBITS-1:0]  en_q,
  output logic              sw_force
);
  logic             hit, wr_hit;
  logic [NBITS-1:0] nxt;
  logic [NBITS-1:0] flags_q;

  assign hit    = (bus_addr == REG_ADDR);
  assign wr_hit = bus_we && hit && !in_rst;

  // read operand of set/clear is the stored enable value
  always_comb begin
    case (bus_op)
      OP_SET:   nxt = en_q | bus_wdata;
      OP_CLEAR: nxt = en_q & ~bus_wdata;
      default:  nxt = bus_wdata;
    endcase
  end

  assign sw_force = wr_hit && nxt[B_SW];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      en_q    <= '0;
      flags_q <= POR_FLAG;
    end else begin
      if (wr_hit)  en_q    <= nxt & EN_MASK;
      if (capture) flags_q <= cause;
    end
  end

  assign rdata = hit ? flags_q : '0;
endmodule

// File: rtl/rstcause_ctrl.sv
module rstcause_ctrl
  import rstcause_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h3C,
  parameter int                STRETCH  = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              pin_req,
  input  logic              wdt_req,
  input  logic              mcd_req,
  input  logic              flash_req,
  input  logic              cmp_n,
  input  logic              rtc_req,
  input  logic              vmon_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [1:0]        bus_op,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              sys_rst,
  output logic              en_rtc,
  output logic              en_cmp,
  output logic              en_mcd,
  output logic              en_vmon
);
  logic [NBITS-1:0] en_q, req, grant;
  logic             any, sw_force, capture;

  always_comb begin
    req          = '0;
    req[B_PIN]   = pin_req;
    req[B_WDT]   = wdt_req;
    req[B_FLASH] = flash_req;
    req[B_SW]    = sw_force;
    req[B_VMON]  = vmon_req & en_q[B_VMON];
    req[B_MCD]   = mcd_req  & en_q[B_MCD];
    req[B_CMP]   = !cmp_n   & en_q[B_CMP];
    req[B_RTC]   = rtc_req  & en_q[B_RTC];
  end

  rstcause_arbiter arb_i (
    .req   (req),
    .grant (grant),
    .any   (any)
  );

  assign capture = any && !sys_rst;

  rstcause_stretch #(.LEN(STRETCH)) str_i (
    .clk    (clk),
    .por_n  (por_n),
    .trig   (capture),
    .active (sys_rst)
  );

  rstcause_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) reg_i (
    .clk       (clk),
    .por_n     (por_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_op    (bus_op),
    .bus_wdata (bus_wdata),
    .in_rst    (sys_rst),
    .capture   (capture),
    .cause     (grant),
    .rdata     (bus_rdata),
    .en_q      (en_q),
    .sw_force  (sw_force)
  );

  assign en_rtc  = en_q[B_RTC];
  assign en_cmp  = en_q[B_CMP];
  assign en_mcd  = en_q[B_MCD];
  assign en_vmon = en_q[B_VMON];
endmodule

// File: rtl/rstcause_chk.sv
module rstcause_chk #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h3C,
  parameter int                STRETCH  = 16
) (
  input logic              clk,
  input logic              por_n,
  input logic              pin_req,
  input logic              wdt_req,
  input logic              mcd_req,
  input logic              flash_req,
  input logic              cmp_n,
  input logic              rtc_req,
  input logic              vmon_req,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [7:0]        bus_rdata,
  input logic              sys_rst,
  input logic              en_rtc,
  input logic              en_cmp,
  input logic              en_mcd,
  input logic              en_vmon
);
  localparam int CW = $clog2(STRETCH + 2);
  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                              hi_cnt <= '0;
    else if (sys_rst && hi_cnt != CW'(STRETCH + 1)) hi_cnt <= hi_cnt + CW'(1);
    else if (!sys_rst)                       hi_cnt <= '0;
  end

  AST_STRETCH_LEN: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> hi_cnt == CW'(STRETCH)); // R8

  AST_STRETCH_MAX: assert property (@(posedge clk) disable iff (!por_n)
    hi_cnt <= CW'(STRETCH)); // R8

  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!por_n)
    (bus_addr == REG_ADDR) |-> $onehot(bus_rdata)); // R7

  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst && $past(sys_rst) && bus_addr == REG_ADDR && $past(bus_addr) == REG_ADDR)
      |-> $stable(bus_rdata)); // R9

  AST_EN_HELD: assert property (@(posedge clk) disable iff (!por_n)
    $past(sys_rst) |-> $stable({en_rtc, en_cmp, en_mcd, en_vmon})); // R9

  AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst && !pin_req && !wdt_req && !flash_req && !(mcd_req && en_mcd) &&
     !(!cmp_n && en_cmp) && !(rtc_req && en_rtc) && !(vmon_req && en_vmon) &&
     !(bus_we && bus_addr == REG_ADDR)) |=> !sys_rst); // R4

  AST_ALWAYS_SRC: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst && (pin_req || wdt_req || flash_req)) |=> sys_rst); // R5
endmodule

bind rstcause_ctrl rstcause_chk #(
  .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .STRETCH(STRETCH)
) chk_i (
  .clk(clk), .por_n(por_n), .pin_req(pin_req), .wdt_req(wdt_req),
  .mcd_req(mcd_req), .flash_req(flash_req), .cmp_n(cmp_n), .rtc_req(rtc_req),
  .vmon_req(vmon_req), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_rdata(bus_rdata), .sys_rst(sys_rst), .en_rtc(en_rtc), .en_cmp(en_cmp),
  .en_mcd(en_mcd), .en_vmon(en_vmon)
);

// File: tb/rstcause_ctrl_tb_top.sv
module rstcause_ctrl_tb_top;
  localparam logic [7:0] RA = 8'h3C;
  localparam int WD_CYCLES = 190000;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic pin_req = 0, wdt_req = 0, mcd_req = 0, flash_req = 0;
  logic cmp_n = 1, rtc_req = 0, vmon_req = 0;
  logic [7:0] bus_addr = RA;
  logic bus_we = 0;
  logic [1:0] bus_op = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic sys_rst, en_rtc, en_cmp, en_mcd, en_vmon;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  rstcause_ctrl dut_i (
    .clk(clk), .por_n(por_n), .pin_req(pin_req), .wdt_req(wdt_req),
    .mcd_req(mcd_req), .flash_req(flash_req), .cmp_n(cmp_n), .rtc_req(rtc_req),
    .vmon_req(vmon_req), .bus_addr(bus_addr), .bus_we(bus_we), .bus_op(bus_op),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_rst(sys_rst),
    .en_rtc(en_rtc), .en_cmp(en_cmp), .en_mcd(en_mcd), .en_vmon(en_vmon)
  );

  function automatic logic [7:0] en_out();
    return {en_rtc, 1'b0, en_cmp, 2'b00, en_mcd, en_vmon, 1'b0};
  endfunction

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic idle();
    pin_req = 0; wdt_req = 0; mcd_req = 0; flash_req = 0;
    cmp_n = 1; rtc_req = 0; vmon_req = 0; bus_we = 0;
  endtask

  task automatic bus_wr(input logic [1:0] op, input logic [7:0] d);
    @(negedge clk);
    bus_op = op; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  // called one negedge after the capture edge; checks the stretch end
  task automatic wait_stretch(input string rq);
    repeat (15) @(negedge clk);
    chk(rq, {7'd0, sys_rst}, 8'd1);
    @(negedge clk);
    chk(rq, {7'd0, sys_rst}, 8'd0);
  endtask

  function automatic logic [7:0] winner(input logic [7:0] g);
    int prio[8] = '{1, 0, 3, 2, 6, 5, 7, 4};
    for (int r = 0; r < 8; r++)
      if (g[prio[r]]) return 8'(1 << prio[r]);
    return 8'h00;
  endfunction

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] exp_flags;
    // R1: power-on state
    repeat (3) @(negedge clk);
    chk("R1 por flags", bus_rdata, 8'h02);
    chk("R1 por enables", en_out(), 8'h00);
    chk("R1 por rst", {7'd0, sys_rst}, 8'd1);
    por_n = 1;
    wait_stretch("R1 por stretch");

    // R2: address decode
    bus_addr = 8'h3D;
    @(negedge clk);
    chk("R2 other addr read", bus_rdata, 8'h00);
    bus_wr(2'd0, 8'hA6);
    chk("R2 other addr write", en_out(), 8'h00);
    bus_addr = RA;

    // R11 / R6: set and clear operations on enables
    bus_wr(2'd1, 8'h84);
    chk("R11 set", en_out(), 8'h84);
    bus_wr(2'd2, 8'h80);
    chk("R11 clear", en_out(), 8'h04);
    bus_wr(2'd1, 8'h22);
    chk("R11 set2", en_out(), 8'h26);
    bus_wr(2'd2, 8'h10);
    chk("R11 clear bit4 no force", {7'd0, sys_rst}, 8'd0);
    bus_wr(2'd0, 8'h26);
    chk("R6 write 0 no force", {7'd0, sys_rst}, 8'd0);
    chk("R3 readback flags", bus_rdata, 8'h02);
    @(negedge clk);
    bus_op = 2'd1; bus_wdata = 8'h10; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
    chk("R11 set bit4 forces", {7'd0, sys_rst}, 8'd1);
    chk("R6 sw flag", bus_rdata, 8'h10);
    chk("R7 enables kept", en_out(), 8'h26);
    wait_stretch("R8 sw stretch");

    // R9: activity during reset is ignored
    @(negedge clk);
    pin_req = 1;
    @(negedge clk);
    pin_req = 0;
    chk("R5 pin flag", bus_rdata, 8'h01);
    @(negedge clk);
    wdt_req = 1; bus_op = 2'd0; bus_wdata = 8'hFF; bus_we = 1;
    @(negedge clk);
    idle();
    repeat (13) @(negedge clk);
    chk("R9 stretch not extended", {7'd0, sys_rst}, 8'd1);
    @(negedge clk);
    chk("R9 stretch end", {7'd0, sys_rst}, 8'd0);
    chk("R9 flags held", bus_rdata, 8'h01);
    chk("R9 enables held", en_out(), 8'h26);

    // Sweep: enable combos x source subsets (R3 R4 R5 R6 R7 R8 R10)
    exp_flags = 8'h01;
    for (int e = 0; e < 16; e++) begin
      for (int s = 0; s < 256; s++) begin
        logic [7:0] en8, src, gated, w;
        en8 = {e[3], 1'b0, e[2], 2'b00, e[1], e[0], 1'b0};
        src = 8'(s);
        bus_wr(2'd0, en8);
        chk("R3 enable write", en_out(), en8);
        gated = src & (en8 | 8'h59);
        w = winner(gated);
        @(negedge clk);
        pin_req = src[0]; vmon_req = src[1]; mcd_req = src[2]; wdt_req = src[3];
        cmp_n = !src[5]; flash_req = src[6]; rtc_req = src[7];
        if (src[4]) begin
          bus_op = 2'd0; bus_wdata = en8 | 8'h10; bus_we = 1;
        end
        @(negedge clk);
        idle();
        if (w != 8'h00) begin
          chk("R10 captured flag", bus_rdata, w);
          chk("R7 enables kept", en_out(), en8);
          chk("R8 rst raised", {7'd0, sys_rst}, 8'd1);
          wait_stretch("R8 sweep stretch");
          exp_flags = w;
        end else begin
          chk("R4 gated ignored rst", {7'd0, sys_rst}, 8'd0);
          chk("R4 gated ignored flags", bus_rdata, exp_flags);
        end
      end
    end

    // R1: power-on in mid-run clears enables
    bus_wr(2'd0, 8'hA6);
    @(negedge clk);
    por_n = 0;
    @(negedge clk);
    chk("R1 por clears enables", en_out(), 8'h00);
    chk("R1 por flag", bus_rdata, 8'h02);
    por_n = 1;
    wait_stretch("R1 por stretch2");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule